// File: doc/BRIEF.md
# AES-128 Key Schedule Engine with Memory Mailbox

This block computes the complete AES-128 key schedule in hardware for a host processor that shares a single 32-bit block-RAM port with it. The host places a 128-bit cipher key in a fixed key area of the RAM, then writes any nonzero value to a flag word. The engine polls that flag word. When it sees the flag set, it fetches the key one word at a time and runs a word-serial expansion core. The core produces one schedule word per clock using the rotate, byte-substitute and round-constant rules.

When the core reports that the schedule is complete, the engine writes all 44 words to consecutive RAM locations, with the initial key words first. It then writes zero to the flag word. A cleared flag tells the host that the round keys are ready. The engine never signals the host in any other way, so the host simply waits for the flag to read back zero.

The RAM port returns read data one clock after the address is presented. Writes are always whole 32-bit words. Base addresses and the round count are parameters. Their defaults are: flag at byte 0x00, key at 0x10, schedule at 0x20, and 10 rounds.

Top module: `aks_keysched_top`

## Requirements
- R1: After reset, and for as long as the flag word at byte address 0x00 reads zero, the engine presents address 0x00 on every cycle and performs no write.
- R2: Any nonzero 32-bit value in the flag word starts an operation. This includes a value with only bit 31 set.
- R3: After a start, the key words are read in the order 0x10, 0x14, 0x18, 0x1C. The word at 0x10 is schedule word w0, and the word at 0x1C is w3.
- R4: Expansion is launched by a key-enable strobe that lasts exactly one cycle. No schedule word is written until the core reports valid, which is at least 40 cycles after the last key read.
- R5: Every write drives all four byte enables, so the enable value is 4'b1111. When the engine is not writing, the enable value is 4'b0000.
- R6: Schedule word wi, for i from 0 to 43, is written to byte address 0x20 + 4*i, in ascending order of i. For i of 4 or more, wi = w(i-4) XOR t. Here t is w(i-1), except when i is a multiple of 4: then t is the S-box substitution of w(i-1) rotated left by one byte, XOR a round constant placed in the top byte.
- R7: The write of 0x00000000 to address 0x00 is the 45th and final write of an operation, and it immediately follows the write of w43. After it, the engine issues no writes until the flag is set again.
- R8: Starting at 0x01, the round constant is doubled in GF(2^8) for each new round key, so that rounds 9 and 10 use 0x1B and 0x36.
- R9: From the cycle in which the flag becomes nonzero in RAM to the flag-clearing write, an operation takes no more than 100 clock cycles.
- R10: The engine writes nothing outside byte addresses 0x20 to 0xCC and the flag word, so the key words and the word at 0xD0 keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | ADDR_W (8) | Byte address presented to the RAM port |
| mem_rdata | input | 32 | Read data, valid one cycle after its address |
| mem_wdata | output | 32 | Write data |
| mem_we | output | 4 | Byte write enables |

## Verification
The bench uses the default parameters: an 8-bit byte address, bases 0x00, 0x10 and 0x20, and ten rounds. With these values the whole 44-word schedule, the key area and a guard word at 0xD0 fit inside a 64-word RAM model, and the engine can be checked end to end. The top address written, 0xCC, and the round constants 0x1B and 0x36 both come within reach, and the published test key pins down known values of w40 to w43. Three keys are run back to back, each started with a different nonzero flag value. Together they exercise re-arming after the flag clears, the path where a zero flag leaves the engine idle, and the cycle budget.

// File: rtl/aks_pkg.sv
// Package: shared state encoding and GF(2^8) helpers for the key schedule engine.
// Assumes the AES field polynomial x^8+x^4+x^3+x+1.
package aks_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD1,
        ST_RD2,
        ST_RD3,
        ST_RD4,
        ST_SAVE4,
        ST_EXPAND,
        ST_WAIT,
        ST_WRITE,
        ST_CLEAR,
        ST_FINISH
    } seq_state_t;

    // Multiply by x in GF(2^8)
    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    // General GF(2^8) product, shift-and-add
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

endpackage

// File: rtl/aks_sbox.sv
// Module: aks_sbox
// Combinational AES forward S-box for one byte. Computes the field inverse
// as x^254 with a short addition chain, then applies the affine map.
// Assumes: purely combinational use; zero maps to 0x63.
module aks_sbox
    import aks_pkg::*;
(
    input  logic [7:0] byte_in,
    output logic [7:0] byte_out
);
    logic [7:0] p2, p3, p6, p12, p15, p30, p60, p120, p240, p252, inv;

    // Inverse via exponent chain, then affine transform
    always_comb begin
        p2   = gf_mul(byte_in, byte_in);
        p3   = gf_mul(p2, byte_in);
        p6   = gf_mul(p3, p3);
        p12  = gf_mul(p6, p6);
        p15  = gf_mul(p12, p3);
        p30  = gf_mul(p15, p15);
        p60  = gf_mul(p30, p30);
        p120 = gf_mul(p60, p60);
        p240 = gf_mul(p120, p120);
        p252 = gf_mul(p240, p12);
        inv  = gf_mul(p252, p2);
        byte_out = inv
                 ^ {inv[6:0], inv[7]}
                 ^ {inv[5:0], inv[7:6]}
                 ^ {inv[4:0], inv[7:5]}
                 ^ {inv[3:0], inv[7:4]}
                 ^ 8'h63;
    end
endmodule

// File: rtl/aks_expand_core.sv
// Module: aks_expand_core
// Word-serial AES-128 key expansion. A one-cycle key_en loads the four key
// words; one new schedule word is then appended per cycle by shifting the
// whole schedule register left. The oldest word ends in the top bits.
// Assumes: key_en is not raised while a run is in progress.
module aks_expand_core
    import aks_pkg::*;
#(
    parameter int ROUNDS = 10,
    localparam int NK          = 4,
    localparam int TOTAL_WORDS = NK * (ROUNDS + 1),
    localparam int TOTAL_BITS  = 32 * TOTAL_WORDS,
    localparam int CNT_W       = $clog2(TOTAL_WORDS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  key_en,
    input  logic [127:0]          key_in,
    output logic [TOTAL_BITS-1:0] sched_out,
    output logic                  valid
);
    logic [TOTAL_BITS-1:0] sched_q;
    logic [CNT_W-1:0]      cnt_q;
    logic                  busy_q;
    logic [7:0]            rcon_q;
    logic [31:0]           prev_w, old_w, rot_w, sub_w, temp_w, next_w;

    assign prev_w = sched_q[31:0];
    assign old_w  = sched_q[127:96];
    assign rot_w  = {prev_w[23:0], prev_w[31:24]};

    genvar gb;
    generate
        for (gb = 0; gb < 4; gb++) begin : g_sub
            aks_sbox u_sbox (
                .byte_in  (rot_w[8*gb +: 8]),
                .byte_out (sub_w[8*gb +: 8])
            );
        end
    endgenerate

    // Next schedule word from the sliding four-word window
    always_comb begin
        temp_w = (cnt_q[1:0] == 2'b00) ? (sub_w ^ {rcon_q, 24'h000000}) : prev_w;
        next_w = old_w ^ temp_w;
    end

    // Load, step and completion tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sched_q <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            rcon_q  <= 8'h01;
            valid   <= 1'b0;
        end else if (key_en) begin
            sched_q <= TOTAL_BITS'(key_in);
            cnt_q   <= CNT_W'(NK);
            busy_q  <= 1'b1;
            rcon_q  <= 8'h01;
            valid   <= 1'b0;
        end else if (busy_q) begin
            sched_q <= {sched_q[TOTAL_BITS-33:0], next_w};
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q[1:0] == 2'b00) rcon_q <= gf_xtime(rcon_q);
            if (cnt_q == CNT_W'(TOTAL_WORDS - 1)) begin
                busy_q <= 1'b0;
                valid  <= 1'b1;
            end
        end
    end

    assign sched_out = sched_q;
endmodule

// File: rtl/aks_mailbox_seq.sv
// Module: aks_mailbox_seq
// Memory-side sequencer: polls the flag word, reads four key words, starts
// the core, streams the schedule out oldest word first, then clears the flag.
// Assumes: read data arrives one cycle after its address; writes are whole words.
module aks_mailbox_seq
    import aks_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int FLAG_ADDR   = 'h00,
    parameter int KEY_BASE    = 'h10,
    parameter int OUT_BASE    = 'h20,
    parameter int TOTAL_WORDS = 44,
    localparam int TOTAL_BITS = 32 * TOTAL_WORDS,
    localparam int CNT_W      = $clog2(TOTAL_WORDS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [31:0]           mem_rdata,
    input  logic                  core_valid,
    input  logic [TOTAL_BITS-1:0] core_sched,
    output logic                  key_en,
    output logic [127:0]          key_words,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [31:0]           mem_wdata,
    output logic [3:0]            mem_we
);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);
    localparam logic [ADDR_W-1:0] KEY_A  = ADDR_W'(KEY_BASE);
    localparam logic [ADDR_W-1:0] OUT_A  = ADDR_W'(OUT_BASE);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] idx_q;
    logic             flag_rd_q;
    logic [127:0]     key_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (flag_rd_q && (mem_rdata != 32'h0)) state_d = ST_RD1;
            ST_RD1:    state_d = ST_RD2;
            ST_RD2:    state_d = ST_RD3;
            ST_RD3:    state_d = ST_RD4;
            ST_RD4:    state_d = ST_SAVE4;
            ST_SAVE4:  state_d = ST_EXPAND;
            ST_EXPAND: state_d = ST_WAIT;
            ST_WAIT:   if (core_valid) state_d = ST_WRITE;
            ST_WRITE:  if (idx_q == CNT_W'(TOTAL_WORDS - 1)) state_d = ST_CLEAR;
            ST_CLEAR:  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State, word index, key capture and flag-read qualification
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            flag_rd_q <= 1'b0;
            key_q     <= '0;
        end else begin
            state_q   <= state_d;
            flag_rd_q <= (state_q == ST_IDLE) || (state_q == ST_FINISH);
            if (state_q inside {ST_RD2, ST_RD3, ST_RD4, ST_SAVE4})
                key_q <= {key_q[95:0], mem_rdata};
            if (state_q == ST_WAIT)
                idx_q <= '0;
            else if (state_q == ST_WRITE)
                idx_q <= idx_q + 1'b1;
        end
    end

    // Port drive per state
    always_comb begin
        mem_addr  = FLAG_A;
        mem_wdata = 32'h0;
        mem_we    = 4'h0;
        unique case (state_q)
            ST_RD1:  mem_addr = KEY_A;
            ST_RD2:  mem_addr = KEY_A + ADDR_W'(4);
            ST_RD3:  mem_addr = KEY_A + ADDR_W'(8);
            ST_RD4, ST_SAVE4, ST_EXPAND, ST_WAIT:
                     mem_addr = KEY_A + ADDR_W'(12);
            ST_WRITE: begin
                mem_addr  = OUT_A + ADDR_W'({idx_q, 2'b00});
                mem_wdata = core_sched[TOTAL_BITS-1 - 32*int'(idx_q) -: 32];
                mem_we    = 4'hF;
            end
            ST_CLEAR: begin
                mem_addr  = FLAG_A;
                mem_wdata = 32'h0;
                mem_we    = 4'hF;
            end
            default: mem_addr = FLAG_A;
        endcase
    end

    assign key_en    = (state_q == ST_EXPAND);
    assign key_words = key_q;
endmodule

// File: rtl/aks_keysched_top.sv
// Module: aks_keysched_top
// AES-128 key schedule engine behind a shared 32-bit RAM port with a flag
// mailbox. Ties the memory sequencer to the word-serial expansion core.
// Assumes: single-port RAM with one-cycle read latency, host writes key then flag.
module aks_keysched_top #(
    parameter int ADDR_W    = 8,
    parameter int FLAG_ADDR = 'h00,
    parameter int KEY_BASE  = 'h10,
    parameter int OUT_BASE  = 'h20,
    parameter int ROUNDS    = 10,
    localparam int TOTAL_WORDS = 4 * (ROUNDS + 1),
    localparam int TOTAL_BITS  = 32 * TOTAL_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_we
);
    logic                  key_en;
    logic [127:0]          key_words;
    logic [TOTAL_BITS-1:0] core_sched;
    logic                  core_valid;

    aks_mailbox_seq #(
        .ADDR_W      (ADDR_W),
        .FLAG_ADDR   (FLAG_ADDR),
        .KEY_BASE    (KEY_BASE),
        .OUT_BASE    (OUT_BASE),
        .TOTAL_WORDS (TOTAL_WORDS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_rdata  (mem_rdata),
        .core_valid (core_valid),
        .core_sched (core_sched),
        .key_en     (key_en),
        .key_words  (key_words),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we)
    );

    aks_expand_core #(
        .ROUNDS (ROUNDS)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_en    (key_en),
        .key_in    (key_words),
        .sched_out (core_sched),
        .valid     (core_valid)
    );
endmodule

// File: rtl/aks_keysched_chk.sv
// Module: aks_keysched_chk
// Property checker for aks_keysched_top, attached by bind below.
// Assumes: synchronous active-low reset on rst_n.
module aks_keysched_chk #(
    parameter int ADDR_W    = 8,
    parameter int FLAG_ADDR = 'h00,
    parameter int OUT_BASE  = 'h20,
    parameter int ROUNDS    = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic [3:0]        mem_we,
    input logic              key_en,
    input logic              core_valid
);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(OUT_BASE + 4 * (4 * (ROUNDS + 1) - 1));

    logic wr_out;
    logic wr_flag;
    assign wr_out  = (mem_we != 4'h0) && (mem_addr != FLAG_A);
    assign wr_flag = (mem_we != 4'h0) && (mem_addr == FLAG_A);

    assert_whole_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we == 4'h0) || (mem_we == 4'hF));

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        key_en |=> !key_en);

    assert_wait_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out |-> core_valid);

    assert_stride_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_out && $past(wr_out)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(4)));

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flag |-> (mem_wdata == 32'h0));

    assert_clear_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flag |-> ($past(mem_we) == 4'hF && $past(mem_addr) == LAST_A));
endmodule

bind aks_keysched_top aks_keysched_chk #(
    .ADDR_W    (ADDR_W),
    .FLAG_ADDR (FLAG_ADDR),
    .OUT_BASE  (OUT_BASE),
    .ROUNDS    (ROUNDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .key_en     (key_en),
    .core_valid (core_valid)
);

// File: tb/aks_keysched_top_tb.sv
// Bench: directed scenarios against a 64-word RAM model with one-cycle reads.
module aks_keysched_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_addr;
    logic [31:0] mem_rdata = 32'h0;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_we;

    logic [31:0] ram [0:63];
    logic        host_we = 1'b0;
    logic [5:0]  host_idx = '0;
    logic [31:0] host_data = '0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0]  sbox_t [0:255];
    logic [31:0] exp_w  [0:43];

    logic [7:0] wr_log [0:63];
    logic [7:0] rd_log [0:7];
    int wr_n = 0, rd_n = 0;
    logic [7:0] last_rd = 8'h00;
    int k4_cyc = -1, first_wr_cyc = -1, clr_cyc = -1;
    bit clr_seen = 1'b0, bad_we = 1'b0;

    always #2 clk = ~clk;

    aks_keysched_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we)
    );

    // RAM model: engine writes have priority, host writes otherwise
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_we == 4'hF) ram[mem_addr[7:2]] <= mem_wdata;
        else if (host_we)   ram[host_idx] <= host_data;
        mem_rdata <= ram[mem_addr[7:2]];
    end

    // Port monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we != 4'h0 && mem_we != 4'hF) bad_we = 1'b1;
            if (mem_we != 4'h0) begin
                if (wr_n == 0) first_wr_cyc = cyc;
                if (wr_n < 64) wr_log[wr_n] = mem_addr;
                wr_n++;
                if (mem_addr == 8'h00 && !clr_seen) begin
                    clr_seen = 1'b1;
                    clr_cyc = cyc;
                end
            end else if (mem_addr != 8'h00 && mem_addr != last_rd) begin
                if (rd_n < 8) rd_log[rd_n] = mem_addr;
                if (mem_addr == 8'h1C && k4_cyc < 0) k4_cyc = cyc;
                rd_n++;
                last_rd = mem_addr;
            end
        end
    end

    function automatic logic [7:0] tb_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 8'h00;
        logic [7:0] x = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) r ^= x;
            x = x[7] ? ({x[6:0], 1'b0} ^ 8'h1B) : {x[6:0], 1'b0};
        end
        return r;
    endfunction

    // S-box table built by brute-force inverse search
    task automatic build_sbox();
        for (int v = 0; v < 256; v++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] s;
            for (int a = 1; a < 256; a++)
                if (v != 0 && tb_mul(8'(a), 8'(v)) == 8'h01) inv = 8'(a);
            s = 8'h63;
            for (int b = 0; b < 8; b++)
                s[b] = s[b] ^ inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^ inv[(b+7)%8];
            sbox_t[v] = s;
        end
    endtask

    task automatic build_expected(input logic [31:0] k0, k1, k2, k3);
        logic [7:0] rc = 8'h01;
        exp_w[0] = k0; exp_w[1] = k1; exp_w[2] = k2; exp_w[3] = k3;
        for (int i = 4; i < 44; i++) begin
            logic [31:0] t = exp_w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {sbox_t[t[31:24]], sbox_t[t[23:16]], sbox_t[t[15:8]], sbox_t[t[7:0]]};
                t = t ^ {rc, 24'h0};
                rc = tb_mul(rc, 8'h02);
            end
            exp_w[i] = exp_w[i-4] ^ t;
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic host_write(input logic [5:0] idx, input logic [31:0] data);
        @(negedge clk);
        host_we = 1'b1; host_idx = idx; host_data = data;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(mem_addr == 8'h00, "R1", "reset address", 32'(mem_addr), 32'h0);
        check(mem_we == 4'h0, "R1", "reset write enable", 32'(mem_we), 32'h0);
    endtask

    task automatic test_idle_zero_flag();
        bit moved = 1'b0;
        host_write(6'd0, 32'h0);
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (mem_addr != 8'h00 || mem_we != 4'h0) moved = 1'b1;
        end
        check(!moved, "R1", "idle poll stays at 0x00", 32'(moved), 32'h0);
        check(wr_n == 0, "R2", "zero flag starts nothing", 32'(wr_n), 32'h0);
    endtask

    task automatic run_key(input logic [31:0] k0, k1, k2, k3, input logic [31:0] flagv);
        int t0;
        bit order_ok = 1'b1;
        int wn_after;
        build_expected(k0, k1, k2, k3);
        wr_n = 0; rd_n = 0; last_rd = 8'h00; k4_cyc = -1; first_wr_cyc = -1;
        clr_seen = 1'b0; clr_cyc = -1;
        host_write(6'd4, k0); host_write(6'd5, k1);
        host_write(6'd6, k2); host_write(6'd7, k3);
        for (int i = 8; i < 52; i++) host_write(6'(i), 32'hA5A5_0000 | 32'(i));
        host_write(6'd52, 32'h5EE0_0D00);
        host_write(6'd0, flagv);
        t0 = cyc;
        for (int n = 0; n < 300 && !clr_seen; n++) @(negedge clk);
        repeat (5) @(negedge clk);
        check(clr_seen, "R2", "flag value starts run and is cleared", flagv, 32'h0);
        check(ram[0] == 32'h0, "R7", "flag word after run", ram[0], 32'h0);
        check(rd_n >= 4 && rd_log[0] == 8'h10 && rd_log[1] == 8'h14 &&
              rd_log[2] == 8'h18 && rd_log[3] == 8'h1C, "R3", "key read order",
              {rd_log[0], rd_log[1], rd_log[2], rd_log[3]}, 32'h1014181C);
        check(first_wr_cyc - k4_cyc >= 40, "R4", "cycles from last key read to first write",
              32'(first_wr_cyc - k4_cyc), 32'd40);
        for (int i = 0; i < 44; i++)
            check(ram[8+i] == exp_w[i], "R6", $sformatf("schedule word %0d", i), ram[8+i], exp_w[i]);
        for (int i = 0; i < 44; i++)
            if (wr_log[i] != 8'(8'h20 + 4*i)) order_ok = 1'b0;
        check(order_ok, "R6", "write addresses ascend from 0x20", 32'(order_ok), 32'h1);
        check(wr_n == 45 && wr_log[44] == 8'h00, "R7", "flag clear is 45th write",
              32'(wr_n), 32'd45);
        check(ram[48] == exp_w[40] && ram[51] == exp_w[43], "R8", "final round key words",
              ram[48], exp_w[40]);
        check(clr_cyc - t0 <= 100, "R9", "cycles to flag clear", 32'(clr_cyc - t0), 32'd100);
        check(ram[4] == k0 && ram[7] == k3, "R10", "key words untouched", ram[4], k0);
        check(ram[52] == 32'h5EE0_0D00, "R10", "guard word at 0xD0", ram[52], 32'h5EE0_0D00);
        check(!bad_we, "R5", "byte enables all or none", 32'(bad_we), 32'h0);
        wn_after = wr_n;
        repeat (30) @(negedge clk);
        check(wr_n == wn_after, "R7", "no writes after flag cleared", 32'(wr_n), 32'(wn_after));
    endtask

    initial begin
        build_sbox();
        repeat (5) @(posedge clk);
        test_reset();
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_idle_zero_flag();
        run_key(32'h2b7e1516, 32'h28aed2a6, 32'habf71588, 32'h09cf4f3c, 32'h0000_0001);
        check(exp_w[40] == 32'hd014f9a8 && exp_w[43] == 32'hb6630ca6, "R8",
              "published schedule words w40 and w43", exp_w[43], 32'hb6630ca6);
        check(ram[51] == 32'hb6630ca6, "R6", "published w43 in RAM", ram[51], 32'hb6630ca6);
        run_key(32'h0, 32'h0, 32'h0, 32'h0, 32'h8000_0000);
        run_key(32'hffffffff, 32'h01234567, 32'h89abcdef, 32'hdeadbeef, 32'h1234_5678);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule